// File: doc/BRIEF.md
# ALU with Condition-Flag Register

This block is the arithmetic stage of a small single-cycle processor core. It combines two operands with either a wrapping addition or a bitwise NOR and presents the result in the same cycle. Next to it sits a three-bit status register that records whether the result was negative, whether a signed addition overflowed, and whether the result was zero. The register feeds the condition logic of the instruction that follows.

The status register never keeps a value for longer than one instruction. On each clock edge it either takes the flags of the current operation (when the write strobe is high) or returns to all zeros. An instruction that branches on the flags raises the clear strobe, which empties the register. Clear wins over write. Synchronous reset also empties the register.

Top module: `cf_alu_flags`

## Requirements
- R1: While reset is high, the next clock edge sets `flags` to 3'b000.
- R2: With `op_sel`=0 (add), `result` equals `op_a + op_b` modulo 2^WIDTH in the same cycle.
- R3: With `op_sel`=1 (NOR), `result` equals `~(op_a | op_b)` in the same cycle. NOR of 0x00000005 and 0x0000000A gives 0xFFFFFFF0.
- R4: `flags` bit 2 is the negative flag, bit 1 is the overflow flag and bit 0 is the zero flag. After a write edge they describe the result present before that edge.
- R5: After a write, bit 2 equals the most significant bit of the result, for both add and NOR.
- R6: After an add is written, bit 1 is 1 exactly when both operands have the same sign bit and the result's sign bit differs. Both 0xFFFFFFFF + 0x80000000 and 0x7FFFFFFF + 0x00000001 set it.
- R7: After a NOR is written, bit 1 is 0.
- R8: After a write, bit 0 is 1 exactly when the result is zero.
- R9: An edge with `flag_clr` high sets `flags` to 3'b000.
- R10: An edge with both `flag_clr` and `flag_wr` high sets `flags` to 3'b000.
- R11: An edge with neither strobe high sets `flags` to 3'b000, so flags are visible for exactly one cycle after they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 1 | Operation: 0 = add, 1 = NOR |
| flag_wr | input | 1 | Capture the new flags at the next edge |
| flag_clr | input | 1 | Empty the status register at the next edge (priority over write) |
| result | output | WIDTH | Combinational operation result |
| flags | output | 3 | Registered status: {negative, overflow, zero} |

## Verification
The bench builds two instances. The first uses the default WIDTH of 32 and runs directed cases: the NOR/add chain with the stated operand values, the two signed-overflow corners, zero results, and every combination of the strobes. The second uses WIDTH of 4, where all 256 operand pairs under both operations can be applied. This checks every combination of sign and carry for the overflow, negative and zero flags against the behavioural model.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_NOR = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
  } status_t;

  localparam int STATUS_W = 3;
endpackage

// File: rtl/cf_arith.sv
module cf_arith #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  cf_pkg::alu_op_e  op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      cf_pkg::OP_ADD: res_o = a_i + b_i;
      cf_pkg::OP_NOR: res_o = ~(a_i | b_i);
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/cf_flag_gen.sv
module cf_flag_gen #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] res_i,
  input  cf_pkg::alu_op_e  op_i,
  output cf_pkg::status_t  next_o
);
  localparam int MSB = WIDTH - 1;

  logic same_sign;
  logic sign_flip;

  assign same_sign = (a_i[MSB] == b_i[MSB]);
  assign sign_flip = (res_i[MSB] != a_i[MSB]);

  always_comb begin
    next_o.neg  = res_i[MSB];
    next_o.zero = (res_i == '0);
    next_o.ovf  = (op_i == cf_pkg::OP_ADD) && same_sign && sign_flip;
  end
endmodule

// File: rtl/cf_status_reg.sv
module cf_status_reg (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic            clr_i,
  input  cf_pkg::status_t next_i,
  output cf_pkg::status_t q_o
);
  logic load;

  assign load = wr_i && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || !load) begin
      q_o <= '0;
    end else begin
      q_o <= next_i;
    end
  end
endmodule

// File: rtl/cf_alu_flags.sv
module cf_alu_flags #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             op_sel,
  input  logic             flag_wr,
  input  logic             flag_clr,
  output logic [WIDTH-1:0] result,
  output logic [2:0]       flags
);
  cf_pkg::alu_op_e op;
  cf_pkg::status_t status_next;
  cf_pkg::status_t status_q;

  assign op = cf_pkg::alu_op_e'(op_sel);

  cf_arith #(.WIDTH(WIDTH)) arith_i (
    .a_i   (op_a),
    .b_i   (op_b),
    .op_i  (op),
    .res_o (result)
  );

  cf_flag_gen #(.WIDTH(WIDTH)) flag_gen_i (
    .a_i    (op_a),
    .b_i    (op_b),
    .res_i  (result),
    .op_i   (op),
    .next_o (status_next)
  );

  cf_status_reg status_i (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (flag_wr),
    .clr_i  (flag_clr),
    .next_i (status_next),
    .q_o    (status_q)
  );

  assign flags = status_q;
endmodule

// File: rtl/cf_alu_flags_chk.sv
module cf_alu_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         op_sel,
  input logic         flag_wr,
  input logic         flag_clr,
  input logic [W-1:0] result,
  input logic [2:0]   flags
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (flags == 3'b000)); // R9

  AST_CLEAR_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && flag_wr) |=> (flags == 3'b000)); // R10

  AST_IDLE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (!flag_clr && !flag_wr) |=> (flags == 3'b000)); // R11

  AST_NOR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && !flag_clr && op_sel) |=> !flags[1]); // R7

  AST_NEG_TRACKS_MSB: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && !flag_clr) |=> (flags[2] == $past(result[W-1]))); // R5

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && !flag_clr) |=> (flags[0] == ($past(result) == '0))); // R8
endmodule

bind cf_alu_flags cf_alu_flags_chk #(.W(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_sel   (op_sel),
  .flag_wr  (flag_wr),
  .flag_clr (flag_clr),
  .result   (result),
  .flags    (flags)
);

// File: tb/cf_alu_flags_tb_top.sv
`timescale 1ns/1ps
module cf_alu_flags_tb_top;
  localparam int WB = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [WB-1:0] a, b, res;
  logic op, wr, clr;
  logic [2:0] flg;

  logic [WS-1:0] sa, sb, sres;
  logic sop, swr, sclr;
  logic [2:0] sflg;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_flags = 3'b000;
  logic [2:0] exp_sflags = 3'b000;

  cf_alu_flags #(.WIDTH(WB)) dut_i (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .op_sel(op),
    .flag_wr(wr), .flag_clr(clr), .result(res), .flags(flg));

  cf_alu_flags #(.WIDTH(WS)) dut_small_i (
    .clk(clk), .rst(rst), .op_a(sa), .op_b(sb), .op_sel(sop),
    .flag_wr(swr), .flag_clr(sclr), .result(sres), .flags(sflg));

  function automatic logic [63:0] m_res(int w, logic [63:0] x, logic [63:0] y, logic o);
    logic [63:0] msk = (64'd1 << w) - 64'd1;
    return o ? (~(x | y) & msk) : ((x + y) & msk);
  endfunction

  function automatic logic [2:0] m_flags(int w, logic [63:0] x, logic [63:0] y, logic o);
    logic [63:0] r = m_res(w, x, y, o);
    logic sx = x[w-1], sy = y[w-1], sr = r[w-1];
    logic v = !o && (sx == sy) && (sr != sx);
    return {sr, v, (r == 64'd0)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // drive at negedge, check result, clock, check flags
  task automatic step(string tag, logic [WB-1:0] x, logic [WB-1:0] y,
                      logic o, logic w, logic c);
    logic [2:0] nxt;
    a = x; b = y; op = o; wr = w; clr = c;
    #1;
    chk({tag, " result"}, 64'(res), m_res(WB, 64'(x), 64'(y), o));
    nxt = (w && !c) ? m_flags(WB, 64'(x), 64'(y), o) : 3'b000;
    @(posedge clk);
    exp_flags = nxt;
    @(negedge clk);
    chk({tag, " flags"}, 64'(flg), 64'(exp_flags));
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; op = 1'b0; wr = 1'b1; clr = 1'b0;
    sa = '0; sb = '0; sop = 1'b0; swr = 1'b1; sclr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset big", 64'(flg), 64'(3'b000));
    chk("R1 reset small", 64'(sflg), 64'(3'b000));
    rst = 1'b0;

    step("R3 R4 nor 5,A",        32'h5,        32'hA,        1'b1, 1'b1, 1'b0);
    step("R2 R5 add F",          32'hFFFFFFF0, 32'hF,        1'b0, 1'b1, 1'b0);
    step("R6 ovf neg+neg",       32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1, 1'b0);
    step("R6 R5 ovf pos+pos",    32'h7FFFFFFF, 32'h1,        1'b0, 1'b1, 1'b0);
    step("R8 add to zero",       32'h5,        32'hFFFFFFFB, 1'b0, 1'b1, 1'b0);
    step("R7 R8 nor to zero",    32'hFFFFFFFF, 32'h0,        1'b1, 1'b1, 1'b0);
    step("R7 R5 nor all ones",   32'h0,        32'h0,        1'b1, 1'b1, 1'b0);
    step("R2 add wrap no ovf",   32'hFFFFFFFF, 32'h1,        1'b0, 1'b1, 1'b0);
    step("R4 prime neg",         32'h80000000, 32'h1,        1'b0, 1'b1, 1'b0);
    step("R9 clear",             32'h80000000, 32'h1,        1'b0, 1'b0, 1'b1);
    step("R4 prime ovf",         32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b0);
    step("R10 clear beats write",32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b1);
    step("R4 prime zero",        32'h0,        32'h0,        1'b0, 1'b1, 1'b0);
    step("R11 idle drops flags", 32'h0,        32'h0,        1'b0, 1'b0, 1'b0);

    // exhaustive sweep on the narrow instance
    for (int o = 0; o < 2; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          sa = WS'(x); sb = WS'(y); sop = o[0]; swr = 1'b1; sclr = 1'b0;
          #1;
          chk(o[0] ? "R3 sweep result" : "R2 sweep result", 64'(sres),
              m_res(WS, 64'(x), 64'(y), o[0]));
          exp_sflags = m_flags(WS, 64'(x), 64'(y), o[0]);
          @(posedge clk);
          @(negedge clk);
          chk("R5 R6 R7 R8 sweep flags", 64'(sflg), 64'(exp_sflags));
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule